// File: doc/BRIEF.md
# SDRAM Command Decoder and Sequencing Checker

This block monitors the control pins of a four-bank SDRAM interface. On every rising clock edge it turns the clock-enable, chip-select, row/column strobes, write-enable, the auto-precharge address bit and the two bank-select bits into a command code. It keeps a small record for each bank: open or precharged, and a precharge-recovery countdown. It also keeps one record for the burst in flight on the shared data bus. When a command breaks the sequencing rules, the block raises a one-cycle error pulse with a reason code.

A rejected command does not change the tracked state. The checker therefore keeps following the legal history of the bus after a fault. The block also produces two data-path qualifiers from the DQM pin. The first is a write-beat keep flag with zero latency. The second is a read output-enable that drops two edges after DQM is sampled high. Burst length and the precharge recovery time in cycles are static parameters. The block sits beside a memory controller or a bus monitor as a protocol guard.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With CKE high at the previous and the current edge and cs_n low, the pin pattern {ras_n,cas_n,we_n} decodes to the following codes. 111 gives NOP (0). 000 gives mode-register load (2). 001 gives auto refresh (3). 011 gives activate (4). 101 gives read (5). 100 gives write (6). 110 gives burst stop (7). 010 gives precharge (8). cs_n high gives deselect (1). cmd_code, cmd_bank, cmd_col and cmd_ap hold the values sampled at an edge and appear just after that edge.
- R2: The auto-refresh pattern sampled while CKE falls from high to low gives self-refresh entry (9). While in self refresh, an edge with CKE high gives self-refresh exit (10) and leaves self refresh. Every other edge where CKE is low at the current or the previous edge gives the clock-low code (11).
- R3: ba selects bank ba (0..3) for activate, read, write and precharge. bank_open bit i is 1 while bank i is open.
- R4: A precharge with ap high closes every open bank, whatever the value of ba.
- R5: Mode-register load, auto refresh and self-refresh entry while any bank is open raise err_pulse with err_code 1.
- R6: In the two edges after an accepted mode-register load, any command other than NOP, deselect, clock-low or self-refresh exit raises err_code 2. This check has the highest priority.
- R7: A read or write issued in the BL-1 edges that follow an accepted read or write with ap high raises err_code 3. At the edge BL after that command, a read or write to an open bank is accepted. Reads and writes without ap may replace a running burst.
- R8: A read or write to a precharged bank raises err_code 4. An activate to an open bank raises err_code 5.
- R9: A bank closes at a precharge edge, or at edge BL-1 after its auto-precharge read or write. An activate to that bank earlier than TRP edges after the closing edge raises err_code 6. An activate at exactly TRP edges or later is accepted.
- R10: A command that raises err_pulse leaves bank_open and the burst record unchanged.
- R11: An accepted burst stop clears burst_busy. If the burst carried auto precharge, the stop also closes that burst's bank at the same edge.
- R12: A write beat is the edge of an accepted write, or any later edge of that write burst that is not cut short. wr_keep, just after an edge, is 1 exactly when that edge is a write beat and dqm was low.
- R13: With dqm sampled high at edge k, rd_oe is low from edge k+1 until edge k+2. Otherwise rd_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ap | input | 1 | Auto-precharge / all-bank address bit |
| ba | input | 2 | Bank select |
| col | input | COL_W | Column address bits |
| dqm | input | 1 | Data mask pin |
| cmd_code | output | 4 | Decoded command of the last edge |
| cmd_bank | output | 2 | Bank bits of the last edge |
| cmd_col | output | COL_W | Column bits of the last edge |
| cmd_ap | output | 1 | Auto-precharge bit of the last edge |
| err_pulse | output | 1 | One-cycle rule-violation flag |
| err_code | output | 3 | Reason for the violation |
| bank_open | output | 4 | Per-bank open flags |
| burst_busy | output | 1 | Burst beats still pending |
| wr_keep | output | 1 | Write beat kept (not masked) |
| rd_oe | output | 1 | Read data output enable |

## Verification
The decoder is driven with about three hundred random pin patterns with CKE held high. These patterns separate every strobe combination and the deselect case, and they show whether the bank and column fields and the two-edge read mask line up in time. Directed sequences then test each sequencing rule at its edge. They land one edge inside and one edge past the mode-register quiet window, the auto-precharge lockout and the recovery countdown, so an off-by-one in any counter shows up. Further sequences compare precharge of one bank with precharge of all banks, and burst stop with and without auto precharge. A last group walks self refresh and plain clock-low periods, so the self-refresh exit is checked against a simple return of the clock.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_DESEL   = 4'd1,
    CMD_MRS     = 4'd2,
    CMD_REF     = 4'd3,
    CMD_ACT     = 4'd4,
    CMD_RD      = 4'd5,
    CMD_WR      = 4'd6,
    CMD_BST     = 4'd7,
    CMD_PRE     = 4'd8,
    CMD_SR_IN   = 4'd9,
    CMD_SR_OUT  = 4'd10,
    CMD_CKE_LOW = 4'd11
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE        = 3'd0,
    ERR_NOT_IDLE    = 3'd1,
    ERR_MRS_QUIET   = 3'd2,
    ERR_AP_LOCK     = 3'd3,
    ERR_BANK_CLOSED = 3'd4,
    ERR_BANK_OPEN   = 3'd5,
    ERR_TRP         = 3'd6
  } err_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  logic       cke_q;
  logic       sref_q;
  logic [2:0] strobes;

  assign strobes = {ras_n, cas_n, we_n};

  always_comb begin
    if (sref_q) begin
      cmd = cke ? CMD_SR_OUT : CMD_CKE_LOW;
    end else if (!cke_q) begin
      cmd = CMD_CKE_LOW;
    end else if (!cke) begin
      cmd = (!cs_n && strobes == 3'b001) ? CMD_SR_IN : CMD_CKE_LOW;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case (strobes)
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b1;
      sref_q <= 1'b0;
    end else begin
      cke_q <= cke;
      if (cmd == CMD_SR_IN)       sref_q <= 1'b1;
      else if (cmd == CMD_SR_OUT) sref_q <= 1'b0;
    end
  end

  // R2
  sref_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (sref_q && cke) |=> !sref_q);
endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int TRP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic set_open,
  input  logic close,
  output logic open_q,
  output logic trp_busy
);
  localparam int TRP_W = (TRP > 1) ? $clog2(TRP + 1) : 1;

  logic [TRP_W-1:0] trp_q;

  assign trp_busy = (trp_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      trp_q  <= '0;
    end else if (close) begin
      open_q <= 1'b0;
      trp_q  <= TRP_W'(TRP - 1);
    end else begin
      if (set_open) open_q <= 1'b1;
      if (trp_busy) trp_q <= trp_q - TRP_W'(1);
    end
  end

  // R9
  trp_open_chk: assert property (@(posedge clk) disable iff (rst)
    !(open_q && trp_busy));
endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track
  import sdram_guard_pkg::*;
#(
  parameter int BL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_ap,
  input  logic              start_wr,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              stop,
  output logic              busy,
  output logic              wr_beat,
  output logic [NUM_BANKS-1:0] close_vec
);
  localparam int REM_W = (BL > 1) ? $clog2(BL) : 1;

  logic [REM_W-1:0]  rem_q;
  logic              ap_q;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;

  assign busy    = (rem_q != '0);
  assign wr_beat = start ? start_wr : (busy && wr_q && !stop);

  always_comb begin
    close_vec = '0;
    if (start) begin
      if (start_ap && BL == 1) close_vec = NUM_BANKS'(1) << start_bank;
    end else if (busy && ap_q && (stop || rem_q == REM_W'(1))) begin
      close_vec = NUM_BANKS'(1) << bank_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      ap_q   <= 1'b0;
      wr_q   <= 1'b0;
      bank_q <= '0;
    end else if (start) begin
      rem_q  <= REM_W'(BL - 1);
      ap_q   <= (BL > 1) ? start_ap : 1'b0;
      wr_q   <= start_wr;
      bank_q <= start_bank;
    end else if (stop) begin
      rem_q <= '0;
      ap_q  <= 1'b0;
    end else if (busy) begin
      rem_q <= rem_q - REM_W'(1);
      if (rem_q == REM_W'(1)) ap_q <= 1'b0;
    end
  end

  // R7
  burst_ap_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ap_q);
endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dqm,
  output logic rd_oe
);
  logic [RD_LAT-1:0] mask_sh;

  generate
    for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)        mask_sh[s] <= 1'b0;
        else if (s == 0) mask_sh[s] <= dqm;
        else            mask_sh[s] <= mask_sh[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign rd_oe = ~mask_sh[RD_LAT-1];
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int BL     = 4,
  parameter int TRP    = 3,
  parameter int COL_W  = 8,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             ap,
  input  logic [1:0]       ba,
  input  logic [COL_W-1:0] col,
  input  logic             dqm,
  output logic [3:0]       cmd_code,
  output logic [1:0]       cmd_bank,
  output logic [COL_W-1:0] cmd_col,
  output logic             cmd_ap,
  output logic             err_pulse,
  output logic [2:0]       err_code,
  output logic [3:0]       bank_open,
  output logic             burst_busy,
  output logic             wr_keep,
  output logic             rd_oe
);
  localparam int NB = NUM_BANKS;

  cmd_e          cmd;
  err_e          err;
  logic          accept;
  logic          idle_cmd;
  logic [NB-1:0] open_vec;
  logic [NB-1:0] trp_vec;
  logic [NB-1:0] set_vec;
  logic [NB-1:0] pre_vec;
  logic [NB-1:0] burst_close;
  logic [NB-1:0] close_vec;
  logic [NB-1:0] sel_vec;
  logic [1:0]    quiet_q;
  logic          ap_lock;
  logic          busy;
  logic          wr_beat;
  logic          burst_start;
  logic          burst_stop;
  logic          ap_busy_q;

  sdram_cmd_decode u_decode (
    .clk   (clk),
    .rst   (rst),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  assign sel_vec  = NB'(1) << ba;
  assign idle_cmd = (cmd == CMD_NOP) || (cmd == CMD_DESEL) ||
                    (cmd == CMD_CKE_LOW) || (cmd == CMD_SR_OUT);
  assign ap_lock  = busy && ap_busy_q;

  always_comb begin
    err = ERR_NONE;
    if (quiet_q != 2'd0 && !idle_cmd) begin
      err = ERR_MRS_QUIET;
    end else begin
      case (cmd)
        CMD_MRS, CMD_REF, CMD_SR_IN: begin
          if (|open_vec) err = ERR_NOT_IDLE;
        end
        CMD_ACT: begin
          if (open_vec[ba])     err = ERR_BANK_OPEN;
          else if (trp_vec[ba]) err = ERR_TRP;
        end
        CMD_RD, CMD_WR: begin
          if (ap_lock)           err = ERR_AP_LOCK;
          else if (!open_vec[ba]) err = ERR_BANK_CLOSED;
        end
        default: err = ERR_NONE;
      endcase
    end
  end

  assign accept      = (err == ERR_NONE);
  assign set_vec     = (accept && cmd == CMD_ACT) ? sel_vec : '0;
  assign pre_vec     = (accept && cmd == CMD_PRE) ? (ap ? open_vec : (sel_vec & open_vec)) : '0;
  assign close_vec   = pre_vec | burst_close;
  assign burst_start = accept && (cmd == CMD_RD || cmd == CMD_WR);
  assign burst_stop  = accept && (cmd == CMD_BST);

  generate
    for (genvar i = 0; i < NB; i++) begin : g_bank
      sdram_bank_state #(.TRP(TRP)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_open (set_vec[i]),
        .close    (close_vec[i]),
        .open_q   (open_vec[i]),
        .trp_busy (trp_vec[i])
      );
    end
  endgenerate

  sdram_burst_track #(.BL(BL)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .start      (burst_start),
    .start_ap   (ap),
    .start_wr   (cmd == CMD_WR),
    .start_bank (ba),
    .stop       (burst_stop),
    .busy       (busy),
    .wr_beat    (wr_beat),
    .close_vec  (burst_close)
  );

  sdram_dqm_pipe #(.RD_LAT(RD_LAT)) u_dqm (
    .clk   (clk),
    .rst   (rst),
    .dqm   (dqm),
    .rd_oe (rd_oe)
  );

  // lockout flag kept beside the burst record: set by an accepted
  // auto-precharge start, dropped at a stop or when beats run out
  always_ff @(posedge clk) begin
    if (rst) begin
      ap_busy_q <= 1'b0;
    end else if (burst_start) begin
      ap_busy_q <= ap && (BL > 1);
    end else if (burst_stop || |burst_close) begin
      ap_busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q <= 2'd0;
    end else if (accept && cmd == CMD_MRS) begin
      quiet_q <= 2'd2;
    end else if (quiet_q != 2'd0) begin
      quiet_q <= quiet_q - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code  <= CMD_NOP;
      cmd_bank  <= '0;
      cmd_col   <= '0;
      cmd_ap    <= 1'b0;
      err_pulse <= 1'b0;
      err_code  <= ERR_NONE;
      wr_keep   <= 1'b0;
    end else begin
      cmd_code  <= cmd;
      cmd_bank  <= ba;
      cmd_col   <= col;
      cmd_ap    <= ap;
      err_pulse <= !accept;
      err_code  <= err;
      wr_keep   <= wr_beat && !dqm;
    end
  end

  assign bank_open  = open_vec;
  assign burst_busy = busy;

  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_MRS && !err_pulse) |=>
      (cmd_code == CMD_NOP || cmd_code == CMD_DESEL || cmd_code == CMD_CKE_LOW ||
       cmd_code == CMD_SR_OUT || (err_pulse && err_code == ERR_MRS_QUIET)));

  // R5
  sref_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_SR_IN && !err_pulse) |-> (bank_open == '0));

  // R8
  closed_chk: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && err_code == ERR_BANK_CLOSED) |-> !$past(open_vec[ba]));
endmodule

// File: tb/sdram_cmd_guard_tb.sv
`timescale 1ns/1ps
module sdram_cmd_guard_tb;
  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_MRS = 4'b0000;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_BST = 4'b0110;
  localparam logic [3:0] P_PRE = 4'b0010;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic [3:0] pins = P_NOP;
  logic       ap = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [7:0] col = 8'd0;
  logic       dqm = 1'b0;

  logic [3:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [7:0] cmd_col;
  logic       cmd_ap;
  logic       err_pulse;
  logic [2:0] err_code;
  logic [3:0] bank_open;
  logic       burst_busy;
  logic       wr_keep;
  logic       rd_oe;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  sdram_cmd_guard u_dut (
    .clk(clk), .rst(rst), .cke(cke),
    .cs_n(pins[3]), .ras_n(pins[2]), .cas_n(pins[1]), .we_n(pins[0]),
    .ap(ap), .ba(ba), .col(col), .dqm(dqm),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .err_pulse(err_pulse), .err_code(err_code), .bank_open(bank_open),
    .burst_busy(burst_busy), .wr_keep(wr_keep), .rd_oe(rd_oe)
  );

  function automatic int exp_code(input logic [3:0] p);
    if (p[3]) return 1;
    case (p[2:0])
      3'b000: return 2;
      3'b001: return 3;
      3'b011: return 4;
      3'b101: return 5;
      3'b100: return 6;
      3'b110: return 7;
      3'b010: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] p, input logic [1:0] b = 2'd0,
                      input logic a = 1'b0, input logic d = 1'b0,
                      input logic k = 1'b1, input logic [7:0] c = 8'd0);
    pins = p; ba = b; ap = a; dqm = d; cke = k; col = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pins = P_NOP; cke = 1'b1; dqm = 1'b0; ap = 1'b0; ba = 2'd0; col = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-reqs actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic prev_dqm;
    logic [3:0] rp;
    logic [1:0] rb;
    logic [7:0] rc;
    logic rd;
    void'($urandom(32'd1234));

    do_reset();
    chk("reset cmd_code", cmd_code, 0);
    chk("reset err_pulse", err_pulse, 0);
    chk("reset bank_open", bank_open, 0);
    chk("reset burst_busy", burst_busy, 0);
    chk("reset rd_oe", rd_oe, 1);
    chk("reset wr_keep", wr_keep, 0);

    // random decode and read-mask timing: R1 R13
    prev_dqm = 1'b0;
    for (int i = 0; i < 300; i++) begin
      rp = 4'($urandom_range(0, 15));
      rb = 2'($urandom_range(0, 3));
      rc = 8'($urandom_range(0, 255));
      rd = ($urandom_range(0, 3) == 0);
      step(rp, rb, 1'($urandom_range(0, 1)), rd, 1'b1, rc);
      chk("R1 random cmd_code", cmd_code, exp_code(rp));
      chk("R1 random cmd_bank", cmd_bank, rb);
      chk("R1 random cmd_col", cmd_col, rc);
      chk("R13 random rd_oe", rd_oe, !prev_dqm);
      prev_dqm = rd;
    end

    do_reset();
    // R6 quiet window after mode-register load
    step(P_MRS);
    chk("R1 mrs code", cmd_code, 2);
    chk("R5 mrs idle ok", err_pulse, 0);
    step(P_ACT, 2'd0);
    chk("R6 act in quiet err", err_code, 2);
    chk("R10 rejected act bank_open", bank_open, 4'b0000);
    step(P_NOP);
    chk("R6 nop no err", err_pulse, 0);
    step(P_ACT, 2'd0);
    chk("R6 act after quiet", err_pulse, 0);
    chk("R3 bank0 open", bank_open, 4'b0001);
    step(P_ACT, 2'd0);
    chk("R8 act open bank", err_code, 5);
    step(P_REF);
    chk("R5 ref with open bank", err_code, 1);
    step(P_RD, 2'd1);
    chk("R8 read closed bank", err_code, 4);
    step(P_ACT, 2'd2);
    chk("R3 bank2 open", bank_open, 4'b0101);

    // R7 R9 R12 auto-precharge write on bank 2, BL=4, TRP=3
    step(P_WR, 2'd2, 1'b1, 1'b0, 1'b1, 8'hA5);
    chk("R1 write code", cmd_code, 6);
    chk("R1 write col", cmd_col, 8'hA5);
    chk("R4 write ap", cmd_ap, 1);
    chk("R12 wr_keep first beat", wr_keep, 1);
    chk("R7 burst busy", burst_busy, 1);
    step(P_RD, 2'd0);
    chk("R7 read during ap lock", err_code, 3);
    chk("R12 wr_keep second beat", wr_keep, 1);
    step(P_NOP, 2'd0, 1'b0, 1'b1);
    chk("R12 wr_keep masked", wr_keep, 0);
    chk("R9 bank2 still open", bank_open, 4'b0101);
    step(P_NOP);
    chk("R9 ap close at last beat", bank_open, 4'b0001);
    chk("R12 wr_keep last beat", wr_keep, 1);
    chk("R7 burst done", burst_busy, 0);
    step(P_RD, 2'd0);
    chk("R7 read after lock", err_pulse, 0);
    step(P_ACT, 2'd2);
    chk("R9 act before trp", err_code, 6);
    step(P_ACT, 2'd2);
    chk("R9 act at trp", err_pulse, 0);
    chk("R9 bank2 reopened", bank_open, 4'b0101);

    // R4 precharge all, then recovery
    step(P_PRE, 2'd3, 1'b1);
    chk("R4 precharge all", bank_open, 4'b0000);
    step(P_ACT, 2'd0);
    chk("R9 act one after pre", err_code, 6);
    step(P_NOP);
    step(P_ACT, 2'd0);
    chk("R9 act three after pre", err_pulse, 0);

    // R11 burst stop
    step(P_RD, 2'd0, 1'b1);
    chk("R11 ap read busy", burst_busy, 1);
    step(P_BST);
    chk("R1 bst code", cmd_code, 7);
    chk("R11 bst ends burst", burst_busy, 0);
    chk("R11 bst closes ap bank", bank_open, 4'b0000);
    step(P_ACT, 2'd1);
    chk("R3 bank1 open", bank_open, 4'b0010);
    step(P_RD, 2'd1);
    step(P_RD, 2'd1);
    chk("R7 plain read replaces burst", err_pulse, 0);
    step(P_BST);
    chk("R11 plain bst busy", burst_busy, 0);
    chk("R11 plain bst keeps bank", bank_open, 4'b0010);
    step(P_PRE, 2'd1);
    chk("R3 single precharge", bank_open, 4'b0000);

    // R2 R5 self refresh and clock-low
    step(P_ACT, 2'd3);
    step(P_REF, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 sref entry code", cmd_code, 9);
    chk("R5 sref with open bank", err_code, 1);
    step(P_NOP, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 in sref clock low", cmd_code, 11);
    step(P_NOP);
    chk("R2 sref exit", cmd_code, 10);
    step(P_PRE, 2'd0, 1'b1);
    chk("R4 precharge all bank3", bank_open, 4'b0000);
    step(P_REF, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R5 sref entry legal", err_pulse, 0);
    step(P_NOP, 2'd0, 1'b0, 1'b0, 1'b0);
    step(P_NOP);
    chk("R2 sref exit again", cmd_code, 10);
    step(P_NOP);
    chk("R1 nop after exit", cmd_code, 0);
    step(P_NOP, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 power-down entry", cmd_code, 11);
    step(P_NOP);
    chk("R2 power-down wake", cmd_code, 11);
    step(P_NOP);
    chk("R2 normal again", cmd_code, 0);

    // R13 directed read mask
    step(P_NOP, 2'd0, 1'b0, 1'b1);
    chk("R13 rd_oe after k", rd_oe, 1);
    step(P_NOP);
    chk("R13 rd_oe after k+1", rd_oe, 0);
    step(P_NOP);
    chk("R13 rd_oe after k+2", rd_oe, 1);

    summary();
    $finish;
  end
endmodule